// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block takes an asynchronous serial line and recovers characters from it. A reload divider turns a clock-enable input into a tick at sixteen times the bit rate. A frame engine locates the falling edge of a start bit, confirms it at mid-bit and samples every following bit at its centre. Characters can be 7, 8 or 9 bits long, may carry an odd or even parity bit, and end with one or two stop bits. Character length, parity, stop count and divisor are static configuration inputs.

Each finished character is copied into a one-entry receive buffer. A fresh transfer raises a one-cycle interrupt request. Overrun, framing and parity errors are latched next to the buffer, together with a summary flag. A read strobe empties the buffer and clears all flags. An optional active-low ready output tells the remote sender when the buffer can take a new character.

Top module: `uart_rx_core`

## Requirements
- R1: One bit lasts 16 × (divisor+1) cycles in which `clk_en` is high. The tick that drives sampling comes once every divisor+1 enables.
- R2: While `rx_en` is 0, no start bit is detected and any frame in progress is abandoned. Such frames leave `buf_full`, `rx_irq` and all flags unchanged.
- R3: A low level on the line is taken as a start bit only if it still reads low 8 oversample ticks later. A shorter low pulse returns the receiver to idle and delivers no character.
- R4: Data bits arrive least significant first. `char_len` selects the length: 0 = 7 bits, 1 = 8 bits, 2 or 3 = 9 bits. The character appears right-aligned in `rx_data`, and the unused upper bits read 0.
- R5: Completing a character while the buffer is empty, or while it is being read in the same cycle, does three things. It loads `rx_data`, sets `buf_full`, and pulses `rx_irq` high for exactly one cycle.
- R6: When `parity_en` is 1, one parity bit follows the data. `err_parity` is set if the count of ones across data and parity is odd with `parity_odd`=0, or even with `parity_odd`=1.
- R7: `two_stop` picks one (0) or two (1) stop bits. `err_framing` is set if any configured stop bit samples low. After a frame ends, the receiver waits for the line to read high before it accepts the next start bit.
- R8: If a character completes while `buf_full` is 1 and no read occurs, `err_overrun` is set. The new character still overwrites `rx_data`, and `rx_irq` is not pulsed.
- R9: `err_sum` is 1 exactly when at least one of `err_overrun`, `err_framing` or `err_parity` is 1.
- R10: A one-cycle `rd_strobe` clears `buf_full`, `err_overrun`, `err_framing` and `err_parity` on the following cycle.
- R11: With `rts_en`=1, `rts_n` is low while the buffer is empty and `rx_en` is 1, and high otherwise. With `rts_en`=0, `rts_n` is held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Clock enable counted by the divider |
| divisor | input | DIV_W | Reload value n; tick every n+1 enables |
| rx_en | input | 1 | Receive enable |
| char_len | input | 2 | 0 = 7 bits, 1 = 8 bits, 2/3 = 9 bits |
| parity_en | input | 1 | A parity bit follows the data |
| parity_odd | input | 1 | 1 = odd, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits |
| rts_en | input | 1 | Enable the ready output |
| rx_line | input | 1 | Serial input, idle high |
| rd_strobe | input | 1 | Buffer read, one cycle |
| rx_data | output | 9 | Buffered character, right-aligned |
| buf_full | output | 1 | Buffer holds an unread character |
| rx_irq | output | 1 | One-cycle receive request |
| err_overrun | output | 1 | Overrun flag |
| err_framing | output | 1 | Framing flag |
| err_parity | output | 1 | Parity flag |
| err_sum | output | 1 | OR of the three error flags |
| rts_n | output | 1 | Active-low ready-to-receive |

## Verification
The bench builds the block with its default parameters: an 8-bit divisor and a 4-bit oversample counter. With those values the divisor can be changed at run time. Most frames use divisor 0, so a bit takes 16 cycles and every character length, parity sense and stop count fits in a short run. One frame uses divisor 2, giving 48 cycles per bit. A wrong reload period would then drift the centre samples by whole bits and corrupt the character.

// File: rtl/uart_rx_pkg.sv
// Package: shared types and constants for the serial receiver.
// Assumes a fixed maximum character width of 9 bits.
package uart_rx_pkg;
    localparam int unsigned CHAR_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;
endpackage

// File: rtl/rx_baud_tick.sv
// Reload divider: emits one tick every (divisor+1) cycles with clk_en high.
// Assumes the divisor is static while frames are in flight.
module rx_baud_tick #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    // Down-counter that reloads from the divisor on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clk_en) begin
            cnt_q <= (cnt_q == '0) ? divisor : cnt_q - 1'b1;
        end
    end

    assign tick = clk_en && (cnt_q == '0);

    // A nonzero divisor forbids ticks on consecutive cycles.
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor != '0) |=> !tick);
endmodule

// File: rtl/rx_frame_fsm.sv
// Frame engine: detects and confirms the start bit, samples data, parity
// and stop bits at mid-bit on the oversample tick, and reports each character.
// Assumes rx_s is already synchronised to clk and idles high.
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int unsigned OVS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_en,
    input  logic              rx_s,
    input  logic [1:0]        char_len,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              two_stop,
    output logic              done,
    output logic [CHAR_W-1:0] data,
    output logic              perr,
    output logic              ferr
);
    localparam logic [OVS_W-1:0] MID_CNT  = OVS_W'((1 << OVS_W) / 2 - 1);
    localparam logic [OVS_W-1:0] LAST_CNT = '1;

    rx_state_e         state_q;
    logic [OVS_W-1:0]  os_cnt_q;
    logic [3:0]        bit_idx_q;
    logic [3:0]        last_idx;
    logic [CHAR_W-1:0] shreg_q;
    logic              par_acc_q;
    logic              ferr_acc_q;
    logic              armed_q;

    // Index of the final data bit for the selected character length.
    always_comb begin
        case (char_len)
            2'd0:    last_idx = 4'd6;
            2'd1:    last_idx = 4'd7;
            default: last_idx = 4'd8;
        endcase
    end

    // Right-align the character that was shifted in from the top.
    assign data = shreg_q >> (4'(CHAR_W - 1) - last_idx);

    // Frame sequencer: one sampling decision per oversample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            os_cnt_q   <= '0;
            bit_idx_q  <= '0;
            shreg_q    <= '0;
            par_acc_q  <= 1'b0;
            ferr_acc_q <= 1'b0;
            armed_q    <= 1'b0;
            done       <= 1'b0;
            perr       <= 1'b0;
            ferr       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!rx_en) begin
                state_q <= ST_IDLE;
                armed_q <= 1'b0;
            end else if (tick) begin
                case (state_q)
                    ST_IDLE: begin
                        if (rx_s) begin
                            armed_q <= 1'b1;
                        end else if (armed_q) begin
                            armed_q  <= 1'b0;
                            os_cnt_q <= '0;
                            state_q  <= ST_START;
                        end
                    end
                    ST_START: begin
                        os_cnt_q <= os_cnt_q + 1'b1;
                        if (os_cnt_q == MID_CNT) begin
                            if (rx_s) begin
                                state_q <= ST_IDLE;
                            end else begin
                                state_q    <= ST_DATA;
                                os_cnt_q   <= '0;
                                bit_idx_q  <= '0;
                                par_acc_q  <= 1'b0;
                                ferr_acc_q <= 1'b0;
                            end
                        end
                    end
                    ST_DATA: begin
                        os_cnt_q <= os_cnt_q + 1'b1;
                        if (os_cnt_q == LAST_CNT) begin
                            shreg_q   <= {rx_s, shreg_q[CHAR_W-1:1]};
                            par_acc_q <= par_acc_q ^ rx_s;
                            bit_idx_q <= bit_idx_q + 1'b1;
                            if (bit_idx_q == last_idx) begin
                                state_q <= parity_en ? ST_PARITY : ST_STOP1;
                            end
                        end
                    end
                    ST_PARITY: begin
                        os_cnt_q <= os_cnt_q + 1'b1;
                        if (os_cnt_q == LAST_CNT) begin
                            par_acc_q <= par_acc_q ^ rx_s;
                            state_q   <= ST_STOP1;
                        end
                    end
                    ST_STOP1: begin
                        os_cnt_q <= os_cnt_q + 1'b1;
                        if (os_cnt_q == LAST_CNT) begin
                            if (two_stop) begin
                                ferr_acc_q <= !rx_s;
                                state_q    <= ST_STOP2;
                            end else begin
                                done    <= 1'b1;
                                ferr    <= !rx_s;
                                perr    <= parity_en & (par_acc_q ^ parity_odd);
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    ST_STOP2: begin
                        os_cnt_q <= os_cnt_q + 1'b1;
                        if (os_cnt_q == LAST_CNT) begin
                            done    <= 1'b1;
                            ferr    <= ferr_acc_q | !rx_s;
                            perr    <= parity_en & (par_acc_q ^ parity_odd);
                            state_q <= ST_IDLE;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // With reception disabled, the engine sits idle on the next cycle.
    assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> state_q == ST_IDLE);

    // A completed character always returns the engine to idle.
    assert_done_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> state_q == ST_IDLE);
endmodule

// File: rtl/rx_buffer_flags.sv
// Receive buffer: holds the last character, raises the request pulse,
// latches error flags and drives the ready output.
// Assumes done is a single-cycle pulse.
module rx_buffer_flags
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [CHAR_W-1:0] data_in,
    input  logic              perr_in,
    input  logic              ferr_in,
    input  logic              rd_strobe,
    input  logic              rx_en,
    input  logic              rts_en,
    output logic [CHAR_W-1:0] rx_data,
    output logic              buf_full,
    output logic              rx_irq,
    output logic              err_overrun,
    output logic              err_framing,
    output logic              err_parity,
    output logic              err_sum,
    output logic              rts_n
);
    logic unread;

    assign unread = buf_full && !rd_strobe;

    // Buffer load, request pulse and flag latching or clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data     <= '0;
            buf_full    <= 1'b0;
            rx_irq      <= 1'b0;
            err_overrun <= 1'b0;
            err_framing <= 1'b0;
            err_parity  <= 1'b0;
        end else begin
            rx_irq <= 1'b0;
            if (done) begin
                rx_data     <= data_in;
                buf_full    <= 1'b1;
                rx_irq      <= !unread;
                err_overrun <= unread;
                err_framing <= ferr_in | (unread & err_framing);
                err_parity  <= perr_in | (unread & err_parity);
            end else if (rd_strobe) begin
                buf_full    <= 1'b0;
                err_overrun <= 1'b0;
                err_framing <= 1'b0;
                err_parity  <= 1'b0;
            end
        end
    end

    assign err_sum = err_overrun | err_framing | err_parity;
    assign rts_n   = rts_en & (buf_full | !rx_en);

    // A request pulse always accompanies a full buffer.
    assert_irq_with_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> buf_full);

    // An overrun never produces a request pulse.
    assert_no_irq_on_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> !rx_irq);

    // Error flags exist only alongside an unread character.
    assert_errors_need_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_sum |-> buf_full);

    // A read with no new character empties the buffer.
    assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !done) |=> (!buf_full && !err_sum));
endmodule

// File: rtl/uart_rx_core.sv
// Top level: synchronises the line, then joins divider, frame engine and
// buffer. Assumes configuration inputs are static during a frame.
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned OVS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              rx_en,
    input  logic [1:0]        char_len,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              two_stop,
    input  logic              rts_en,
    input  logic              rx_line,
    input  logic              rd_strobe,
    output logic [CHAR_W-1:0] rx_data,
    output logic              buf_full,
    output logic              rx_irq,
    output logic              err_overrun,
    output logic              err_framing,
    output logic              err_parity,
    output logic              err_sum,
    output logic              rts_n
);
    logic [1:0]        sync_q;
    logic              tick;
    logic              done;
    logic [CHAR_W-1:0] char_data;
    logic              perr;
    logic              ferr;

    // Two-stage synchroniser on the serial line, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_line};
    end

    rx_baud_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .divisor (divisor),
        .tick    (tick)
    );

    rx_frame_fsm #(.OVS_W(OVS_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rx_en      (rx_en),
        .rx_s       (sync_q[1]),
        .char_len   (char_len),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .two_stop   (two_stop),
        .done       (done),
        .data       (char_data),
        .perr       (perr),
        .ferr       (ferr)
    );

    rx_buffer_flags u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (done),
        .data_in     (char_data),
        .perr_in     (perr),
        .ferr_in     (ferr),
        .rd_strobe   (rd_strobe),
        .rx_en       (rx_en),
        .rts_en      (rts_en),
        .rx_data     (rx_data),
        .buf_full    (buf_full),
        .rx_irq      (rx_irq),
        .err_overrun (err_overrun),
        .err_framing (err_framing),
        .err_parity  (err_parity),
        .err_sum     (err_sum),
        .rts_n       (rts_n)
    );
endmodule

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic [7:0] divisor = 8'd0;
    logic       rx_en = 1'b1;
    logic [1:0] char_len = 2'd1;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       rts_en = 1'b1;
    logic       rx_line = 1'b1;
    logic       rd_strobe = 1'b0;
    logic [8:0] rx_data;
    logic       buf_full, rx_irq, err_overrun, err_framing, err_parity, err_sum, rts_n;

    int checks = 0;
    int failures = 0;
    int irq_cnt = 0;
    int bitcyc = 16;

    always #5 clk = ~clk;

    uart_rx_core u_uart_rx_core (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .divisor(divisor),
        .rx_en(rx_en), .char_len(char_len), .parity_en(parity_en),
        .parity_odd(parity_odd), .two_stop(two_stop), .rts_en(rts_en),
        .rx_line(rx_line), .rd_strobe(rd_strobe), .rx_data(rx_data),
        .buf_full(buf_full), .rx_irq(rx_irq), .err_overrun(err_overrun),
        .err_framing(err_framing), .err_parity(err_parity),
        .err_sum(err_sum), .rts_n(rts_n)
    );

    // Count request pulses away from the active edge.
    always @(negedge clk) if (rst_n && rx_irq) irq_cnt++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rx_line = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] d, input int nbits, input logic bad_par,
                        input logic s1, input logic s2);
        logic par;
        par = 1'b0;
        for (int i = 0; i < nbits; i++) par = par ^ d[i];
        par = par ^ parity_odd ^ bad_par;
        hold(1'b0, bitcyc);
        for (int i = 0; i < nbits; i++) hold(d[i], bitcyc);
        if (parity_en) hold(par, bitcyc);
        hold(s1, bitcyc);
        if (two_stop) hold(s2, bitcyc);
        hold(1'b1, bitcyc);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10 reset buf_full", int'(buf_full), 0);
        check("R9 reset err_sum", int'(err_sum), 0);
        check("R11 reset rts_n", int'(rts_n), 0);
    endtask

    task automatic t_basic8();
        int base;
        base = irq_cnt;
        send(9'h0A5, 8, 1'b0, 1'b1, 1'b1);
        check("R4 8-bit data", int'(rx_data), 'h0A5);
        check("R5 buf_full", int'(buf_full), 1);
        check("R5 one irq", irq_cnt - base, 1);
        check("R9 no errors", int'(err_sum), 0);
        check("R11 rts_n high when full", int'(rts_n), 1);
        do_read();
        check("R10 read empties", int'(buf_full), 0);
        check("R11 rts_n low when empty", int'(rts_n), 0);
    endtask

    task automatic t_lengths();
        char_len = 2'd0; parity_en = 1'b1; parity_odd = 1'b0;
        send(9'h05A, 7, 1'b0, 1'b1, 1'b1);
        check("R4 7-bit data", int'(rx_data), 'h05A);
        check("R6 even parity ok", int'(err_parity), 0);
        do_read();
        char_len = 2'd2; parity_odd = 1'b1;
        send(9'h1C3, 9, 1'b0, 1'b1, 1'b1);
        check("R4 9-bit data", int'(rx_data), 'h1C3);
        check("R6 odd parity ok", int'(err_parity), 0);
        do_read();
        char_len = 2'd1; parity_en = 1'b0; parity_odd = 1'b0;
    endtask

    task automatic t_parity_err();
        parity_en = 1'b1;
        send(9'h037, 8, 1'b1, 1'b1, 1'b1);
        check("R6 parity error", int'(err_parity), 1);
        check("R9 sum on parity", int'(err_sum), 1);
        do_read();
        check("R10 parity cleared", int'(err_parity), 0);
        parity_odd = 1'b1;
        send(9'h0F0, 8, 1'b1, 1'b1, 1'b1);
        check("R6 odd parity error", int'(err_parity), 1);
        do_read();
        parity_en = 1'b0; parity_odd = 1'b0;
    endtask

    task automatic t_framing();
        send(9'h081, 8, 1'b0, 1'b0, 1'b1);
        check("R7 one stop low", int'(err_framing), 1);
        check("R7 data still kept", int'(rx_data), 'h081);
        do_read();
        two_stop = 1'b1;
        send(9'h042, 8, 1'b0, 1'b1, 1'b0);
        check("R7 second stop low", int'(err_framing), 1);
        do_read();
        send(9'h042, 8, 1'b0, 1'b1, 1'b1);
        check("R7 two good stops", int'(err_framing), 0);
        check("R7 two-stop data", int'(rx_data), 'h042);
        do_read();
        two_stop = 1'b0;
    endtask

    task automatic t_overrun();
        int base;
        base = irq_cnt;
        send(9'h011, 8, 1'b0, 1'b1, 1'b1);
        send(9'h0EE, 8, 1'b0, 1'b1, 1'b1);
        check("R8 overrun flag", int'(err_overrun), 1);
        check("R8 data overwritten", int'(rx_data), 'h0EE);
        check("R8 only first irq", irq_cnt - base, 1);
        check("R9 sum on overrun", int'(err_sum), 1);
        do_read();
        check("R10 overrun cleared", int'(err_overrun), 0);
    endtask

    task automatic t_disabled();
        int base;
        base = irq_cnt;
        rx_en = 1'b0;
        @(negedge clk);
        check("R11 rts_n high when disabled", int'(rts_n), 1);
        send(9'h033, 8, 1'b0, 1'b1, 1'b1);
        check("R2 no char when disabled", int'(buf_full), 0);
        check("R2 no irq when disabled", irq_cnt - base, 0);
        rx_en = 1'b1;
        hold(1'b1, bitcyc);
    endtask

    task automatic t_glitch();
        int base;
        base = irq_cnt;
        hold(1'b0, 5);
        hold(1'b1, 3 * bitcyc);
        check("R3 glitch no char", int'(buf_full), 0);
        check("R3 glitch no irq", irq_cnt - base, 0);
        send(9'h0C3, 8, 1'b0, 1'b1, 1'b1);
        check("R3 frame after glitch", int'(rx_data), 'h0C3);
        do_read();
    endtask

    task automatic t_divider();
        divisor = 8'd2; bitcyc = 48;
        hold(1'b1, bitcyc);
        send(9'h06D, 8, 1'b0, 1'b1, 1'b1);
        check("R1 divisor 2 data", int'(rx_data), 'h06D);
        check("R1 divisor 2 full", int'(buf_full), 1);
        do_read();
        divisor = 8'd0; bitcyc = 16;
        hold(1'b1, bitcyc);
    endtask

    task automatic t_rts_off();
        rts_en = 1'b0;
        send(9'h001, 8, 1'b0, 1'b1, 1'b1);
        check("R11 rts_n low when disabled output", int'(rts_n), 0);
        do_read();
        rts_en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic8();
        t_lengths();
        t_parity_err();
        t_framing();
        t_overrun();
        t_disabled();
        t_glitch();
        t_divider();
        t_rts_off();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule